// File: doc/BRIEF.md
# Programmable Reed-Solomon Encoder

This block is a systematic, byte-serial Reed-Solomon encoder over GF(2^8). A block opens on a byte that carries both a valid strobe and a start pulse. Each accepted message byte appears unchanged on the output one cycle later. In parallel, the byte is folded into a remainder register that divides by the generator polynomial of the selected code. The check symbols follow the last message byte with no gap between them. The number of check symbols per codeword is chosen at run time from five values, and each value has its own generator polynomial.

Input bytes can be dealt across up to four independent codewords in turn. This spreads a burst of channel errors over several codewords. The check symbols of those codewords are sent out in the same rotating order. The check-symbol count, the interleave depth and the message length are read with the start byte and hold for the whole block.

Top module: `rs_encoder`

## Requirements
- R1: During reset and in the first cycle after it, `validOut` and `checkOut` are 0. The first block after reset encodes from all-zero remainders.
- R2: A byte with `validIn` and `startIn` both high opens a block, except while check symbols are being emitted. The block captures `paritySel`, `depthSel` and `msgLen` from that byte. `paritySel` maps 0→2, 1→3, 2→4 and 3→6 check symbols, and 4 to 7 map to 8. The depth is D = `depthSel`+1. The block takes `msgLen` bytes per codeword, which is `msgLen`·D input bytes in total, with `msgLen` from 1 to 253 and `msgLen` plus the check count at most 255.
- R3: Every accepted message byte appears on `dataOut` in the next cycle with `validOut`=1 and `checkOut`=0. Cycles with `validIn` low produce no output and are not counted as message bytes.
- R4: While no block is open, bytes offered without `startIn` are ignored and produce no output.
- R5: The field is built on x^8+x^4+x^3+x^2+1, with α = 0x02. For n check symbols, the generator is the product of (x+α^i) for i = 0..n-1. The check symbols of each codeword are the remainder of m(x)·x^n divided by that generator. The full codeword therefore evaluates to zero at α^0 through α^(n-1).
- R6: Input byte j of a block belongs to codeword j mod D. The check symbols go out in n rounds, and each round covers codewords 0 to D-1. Within a codeword, the highest-degree remainder coefficient comes first.
- R7: The first check symbol appears in the cycle after the last message byte is output. The n·D check symbols are contiguous and carry `checkOut`=1. After them, `validOut` is 0.
- R8: While check symbols are being emitted, `validIn`, `startIn` and `dataIn` have no effect.
- R9: Changes to `paritySel`, `depthSel` or `msgLen` after the start byte do not affect the open block.
- R10: A start byte that arrives while message bytes are still being taken abandons the open block and begins a new one from cleared remainders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Input byte strobe |
| startIn | input | 1 | Marks the first byte of a block (qualified by validIn) |
| dataIn | input | 8 | Message byte |
| paritySel | input | 3 | Check-symbol count code |
| depthSel | input | 2 | Interleave depth minus one |
| msgLen | input | 8 | Message bytes per codeword |
| validOut | output | 1 | Output byte strobe |
| dataOut | output | 8 | Forwarded message byte or check symbol |
| checkOut | output | 1 | High when dataOut carries a check symbol |

## Verification
A table of blocks covers every check-symbol code, including an out-of-range code, and every interleave depth. The message lengths run from one byte per codeword up to a full 255-symbol codeword, and one message is all zero. The bench compares the output against its own long division. This separates a wrong generator or wrong remainder feedback from a wrong emission order. A separate syndrome evaluation at the generator roots confirms that the root set starts at α^0. Directed patterns cover valid gaps, stray bytes while idle, inputs during emission, a configuration change in mid-block and a restart. Each of these must leave the encoded stream unchanged.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;
  localparam int SYM_W     = 8;
  localparam int MAX_PAR   = 8;
  localparam int MAX_LANES = 4;
  localparam int LANE_W    = $clog2(MAX_LANES);
  localparam int NUM_MODES = 5;
  localparam int MODE_W    = 3;
  localparam logic [SYM_W-1:0] POLY_LOW = 8'h1D;  // x^8+x^4+x^3+x^2+1 without x^8

  typedef logic [MAX_PAR-1:0][SYM_W-1:0] coefVec_t;

  typedef struct packed {
    logic              load;    // clear all remainders (block start)
    logic              absorb;  // fold dataIn into the selected lane
    logic              emit;    // shift one check symbol out of the lane
    logic [LANE_W-1:0] lane;
    logic [MODE_W-1:0] mode;
  } ctrl_t;

  function automatic int nsymOf(int mode);
    case (mode)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3:       return 6;
      default: return 8;
    endcase
  endfunction

  function automatic logic [SYM_W-1:0] gfMul(logic [SYM_W-1:0] a, logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ POLY_LOW) : (sh << 1);
    end
    return acc;
  endfunction

  // Low-order coefficients of prod (x + a^i), i = 0..nsym-1; the monic top term is implicit.
  function automatic coefVec_t genPoly(int nsym);
    logic [MAX_PAR:0][SYM_W-1:0] g;
    logic [SYM_W-1:0] root;
    g    = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < nsym; i++) begin
      for (int k = MAX_PAR; k > 0; k--) g[k] = g[k-1] ^ gfMul(g[k], root);
      g[0] = gfMul(g[0], root);
      root = gfMul(root, 8'h02);
    end
    return g[MAX_PAR-1:0];
  endfunction
endpackage

// File: rtl/rsenc_ctrl.sv
module rsenc_ctrl
  import rsenc_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic              startIn,
  input  logic [MODE_W-1:0] paritySel,
  input  logic [LANE_W-1:0] depthSel,
  input  logic [LEN_W-1:0]  msgLen,
  output ctrl_t             ctl
);
  typedef enum logic [1:0] {S_IDLE, S_MSG, S_PAR} state_t;

  localparam int PIDX_W = $clog2(MAX_PAR);

  state_t            stateQ;
  logic [MODE_W-1:0] modeQ, curMode;
  logic [LANE_W-1:0] depthQ, curDepth, laneQ, curLane;
  logic [LEN_W-1:0]  lenQ, curLen, cntQ, curCnt;
  logic [PIDX_W-1:0] pIdxQ, parLast;
  logic              startHit, absorb, lastRound, lastMsg, emitting;

  always_comb begin
    emitting  = (stateQ == S_PAR);
    startHit  = validIn && startIn && !emitting;
    absorb    = startHit || (validIn && stateQ == S_MSG);
    curMode   = startHit ? paritySel : modeQ;
    curDepth  = startHit ? depthSel  : depthQ;
    curLen    = startHit ? msgLen    : lenQ;
    curLane   = startHit ? '0 : laneQ;
    curCnt    = startHit ? '0 : cntQ;
    lastRound = ({1'b0, curCnt} + 1'b1) >= {1'b0, curLen};
    lastMsg   = absorb && (curLane == curDepth) && lastRound;
    parLast   = PIDX_W'(nsymOf(int'(modeQ)) - 1);
    ctl       = '{load: startHit, absorb: absorb, emit: emitting, lane: curLane, mode: curMode};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      modeQ  <= '0;
      depthQ <= '0;
      lenQ   <= '0;
      laneQ  <= '0;
      cntQ   <= '0;
      pIdxQ  <= '0;
    end else begin
      if (startHit) begin
        modeQ  <= paritySel;
        depthQ <= depthSel;
        lenQ   <= msgLen;
      end
      if (absorb) begin
        if (lastMsg) begin
          stateQ <= S_PAR;
          laneQ  <= '0;
          pIdxQ  <= '0;
        end else begin
          stateQ <= S_MSG;
          if (curLane == curDepth) begin
            laneQ <= '0;
            cntQ  <= curCnt + 1'b1;
          end else begin
            laneQ <= curLane + 1'b1;
            cntQ  <= curCnt;
          end
        end
      end else if (emitting) begin
        if (laneQ == depthQ) begin
          laneQ <= '0;
          if (pIdxQ == parLast) stateQ <= S_IDLE;
          else                  pIdxQ  <= pIdxQ + 1'b1;
        end else begin
          laneQ <= laneQ + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsenc_dp.sv
module rsenc_dp
  import rsenc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic [SYM_W-1:0] dataIn,
  output logic             validOut,
  output logic             checkOut,
  output logic [SYM_W-1:0] dataOut
);
  localparam int IDX_W = $clog2(MAX_PAR);

  coefVec_t          remQ [MAX_LANES];
  coefVec_t          prod [NUM_MODES];
  coefVec_t          laneRem, nxtRem, shRem, prodSel;
  logic [MODE_W-1:0] modeIdx;
  logic [IDX_W-1:0]  topIdx;
  logic [SYM_W-1:0]  topSym, fb;
  int                nsym;

  // One constant-multiplier bank per check-symbol count.
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam coefVec_t GEN_M = genPoly(nsymOf(m));
    coefVec_t prodM;
    always_comb begin
      for (int k = 0; k < MAX_PAR; k++) prodM[k] = gfMul(fb, GEN_M[k]);
    end
    assign prod[m] = prodM;
  end

  always_comb begin
    modeIdx = (ctl.mode >= MODE_W'(NUM_MODES-1)) ? MODE_W'(NUM_MODES-1) : ctl.mode;
    nsym    = nsymOf(int'(modeIdx));
    topIdx  = IDX_W'(nsym - 1);
    laneRem = ctl.load ? '0 : remQ[ctl.lane];
    topSym  = laneRem[topIdx];
    fb      = dataIn ^ topSym;
    prodSel = prod[modeIdx];
    nxtRem[0] = prodSel[0];
    shRem[0]  = '0;
    for (int k = 1; k < MAX_PAR; k++) begin
      nxtRem[k] = (k < nsym) ? (laneRem[k-1] ^ prodSel[k]) : '0;
      shRem[k]  = (k < nsym) ? laneRem[k-1] : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < MAX_LANES; l++) remQ[l] <= '0;
      validOut <= 1'b0;
      checkOut <= 1'b0;
      dataOut  <= '0;
    end else begin
      if (ctl.load) begin
        for (int l = 0; l < MAX_LANES; l++) remQ[l] <= '0;
      end
      if (ctl.absorb) begin
        remQ[ctl.lane] <= nxtRem;
        dataOut  <= dataIn;
        validOut <= 1'b1;
        checkOut <= 1'b0;
      end else if (ctl.emit) begin
        remQ[ctl.lane] <= shRem;
        dataOut  <= topSym;
        validOut <= 1'b1;
        checkOut <= 1'b1;
      end else begin
        dataOut  <= '0;
        validOut <= 1'b0;
        checkOut <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rs_encoder.sv
module rs_encoder
  import rsenc_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic             startIn,
  input  logic [7:0]       dataIn,
  input  logic [2:0]       paritySel,
  input  logic [1:0]       depthSel,
  input  logic [LEN_W-1:0] msgLen,
  output logic             validOut,
  output logic [7:0]       dataOut,
  output logic             checkOut
);
  ctrl_t ctl;

  rsenc_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .startIn(startIn),
    .paritySel(paritySel), .depthSel(depthSel), .msgLen(msgLen), .ctl(ctl)
  );

  rsenc_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn),
    .validOut(validOut), .checkOut(checkOut), .dataOut(dataOut)
  );
endmodule

module rs_encoder_chk
  import rsenc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [7:0] dataIn,
  input ctrl_t      ctl,
  input logic       validOut,
  input logic [7:0] dataOut,
  input logic       checkOut
);
  // R3
  echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.absorb |=> validOut && !checkOut && dataOut == $past(dataIn));
  // R7
  emit_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit |=> validOut && checkOut);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.absorb && !ctl.emit |=> !validOut && !checkOut);
  // R8
  no_absorb_in_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit |-> !ctl.absorb && !ctl.load);
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit && $past(ctl.emit) |-> ctl.mode == $past(ctl.mode));
  // R2
  start_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> ctl.absorb && ctl.lane == '0);
endmodule

bind rs_encoder rs_encoder_chk u_chk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .ctl(ctl),
  .validOut(validOut), .dataOut(dataOut), .checkOut(checkOut)
);

// File: tb/rs_encoder_tb.sv
`timescale 1ns/1ps
module rs_encoder_tb;
  localparam int BUF = 1200;
  localparam int NVEC = 10;
  // {paritySel, depthSel, msgLen, seed}
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 10, 1}, '{1, 0, 20, 2}, '{2, 1, 15, 3}, '{3, 2, 12, 4},
    '{4, 3, 30, 5}, '{4, 0, 247, 6}, '{0, 3, 1, 7}, '{2, 0, 1, 8},
    '{6, 1, 9, 9}, '{3, 1, 5, 0}
  };

  logic clk = 1'b0, rstN = 1'b0, validIn = 1'b0, startIn = 1'b0;
  logic [7:0] dataIn = '0, msgLen = '0;
  logic [2:0] paritySel = '0;
  logic [1:0] depthSel = '0;
  logic validOut, checkOut;
  logic [7:0] dataOut;

  rs_encoder u_dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .startIn(startIn), .dataIn(dataIn),
    .paritySel(paritySel), .depthSel(depthSel), .msgLen(msgLen),
    .validOut(validOut), .dataOut(dataOut), .checkOut(checkOut)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic       stV [BUF];
  logic       stS [BUF];
  logic [7:0] stD [BUF];
  int nSt, chgAt;
  logic [7:0] gotD [BUF];
  logic       gotC [BUF];
  int         gotCyc [BUF];
  int nGot;
  logic [7:0] msg [BUF];
  int nMsg;
  logic [7:0] expD [BUF];
  logic       expC [BUF];
  int nExp;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gm(logic [7:0] a, logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11D << (i - 8));
    return p[7:0];
  endfunction

  function automatic int nsymFor(int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 3 : (sel == 2) ? 4 : (sel == 3) ? 6 : 8;
  endfunction

  function automatic logic [7:0] genByte(int seed, int j);
    return (seed == 0) ? 8'h00 : 8'(seed * 29 + j * 71 + j * j * 3 + 5);
  endfunction

  // Reference: long division per interleaved codeword, emitted round by round.
  task automatic refExpected(int nsym, int d);
    logic [7:0] g [9];
    logic [7:0] rem [4][8];
    logic [7:0] root, fb;
    for (int k = 0; k < 9; k++) g[k] = 0;
    g[0] = 1; root = 1;
    for (int i = 0; i < nsym; i++) begin
      for (int k = 8; k > 0; k--) g[k] = g[k-1] ^ gm(g[k], root);
      g[0] = gm(g[0], root);
      root = gm(root, 8'h02);
    end
    nExp = 0;
    for (int j = 0; j < nMsg; j++) begin expD[nExp] = msg[j]; expC[nExp] = 0; nExp++; end
    for (int c = 0; c < d; c++) begin
      for (int k = 0; k < 8; k++) rem[c][k] = 0;
      for (int j = c; j < nMsg; j += d) begin
        fb = msg[j] ^ rem[c][nsym-1];
        for (int k = nsym - 1; k > 0; k--) rem[c][k] = rem[c][k-1] ^ gm(fb, g[k]);
        rem[c][0] = gm(fb, g[0]);
      end
    end
    for (int j = 0; j < nsym; j++)
      for (int c = 0; c < d; c++) begin
        expD[nExp] = rem[c][nsym-1-j]; expC[nExp] = 1; nExp++;
      end
  endtask

  task automatic runStim(int extra);
    nGot = 0;
    for (int i = 0; i < nSt + extra; i++) begin
      @(negedge clk);
      if (validOut && nGot < BUF) begin
        gotD[nGot] = dataOut; gotC[nGot] = checkOut; gotCyc[nGot] = i; nGot++;
      end
      if (i == chgAt) begin paritySel = 3'd0; depthSel = 2'd0; msgLen = 8'd1; end
      if (i < nSt) begin validIn = stV[i]; startIn = stS[i]; dataIn = stD[i]; end
      else begin validIn = 0; startIn = 0; dataIn = 8'hA5; end
    end
  endtask

  task automatic compare(string req, bit contig);
    int bad = 0, badC = 0, firstChk = -1, lastMsg = -1, gap = 0;
    check(nGot == nExp, req, "output count", nGot, nExp);
    for (int k = 0; k < nGot && k < nExp; k++) begin
      if (gotD[k] !== expD[k]) begin
        if (bad == 0) $display("FAIL %s byte %0d actual=%0h expected=%0h", req, k, gotD[k], expD[k]);
        bad++;
      end
      if (gotC[k] !== expC[k]) badC++;
      if (expC[k] && firstChk < 0) firstChk = k;
      if (!expC[k]) lastMsg = k;
      if (k > 0 && gotCyc[k] != gotCyc[k-1] + 1 && (contig || expC[k])) gap++;
    end
    checks++; if (bad != 0) errors++;
    check(badC == 0, req, "checkOut flag mismatches", badC, 0);
    check(gap == 0, req, "cycle gaps in output", gap, 0);
    if (firstChk > 0 && lastMsg >= 0 && firstChk < nGot)
      check(gotCyc[firstChk] == gotCyc[lastMsg] + 1, "R7", "first check cycle",
            gotCyc[firstChk], gotCyc[lastMsg] + 1);
  endtask

  task automatic syndromeCheck(int nsym, int d, int len);
    int bad = 0;
    logic [7:0] root, s;
    for (int c = 0; c < d; c++) begin
      root = 1;
      for (int i = 0; i < nsym; i++) begin
        s = 0;
        for (int j = 0; j < len; j++) s = gm(s, root) ^ gotD[(c + j*d) % BUF];
        for (int j = 0; j < nsym; j++) s = gm(s, root) ^ gotD[(len*d + j*d + c) % BUF];
        if (s != 0) bad++;
        root = gm(root, 8'h02);
      end
    end
    check(bad == 0, "R5", "nonzero syndromes", bad, 0);
  endtask

  task automatic plainBlock(int sel, int dsel, int len, int seed, int gapEvery);
    int d = dsel + 1, idx = 0;
    paritySel = 3'(sel); depthSel = 2'(dsel); msgLen = 8'(len);
    nMsg = len * d;
    for (int j = 0; j < nMsg; j++) msg[j] = genByte(seed, j);
    for (int j = 0; j < nMsg; j++) begin
      if (gapEvery > 0 && j % gapEvery == 1) begin
        stV[idx] = 0; stS[idx] = 1; stD[idx] = 8'hEE; idx++;
      end
      stV[idx] = 1; stS[idx] = (j == 0); stD[idx] = msg[j]; idx++;
    end
    nSt = idx;
    refExpected(nsymFor(sel), d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    chgAt = -1;
    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset and after release
    check(!validOut && !checkOut, "R1", "outputs during reset", {validOut, checkOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!validOut && !checkOut, "R1", "outputs after reset", {validOut, checkOut}, 0);

    // R4 stray bytes while idle
    for (int i = 0; i < 5; i++) begin stV[i] = 1; stS[i] = 0; stD[i] = 8'(i + 3); end
    nSt = 5;
    runStim(3);
    check(nGot == 0, "R4", "outputs from bytes without start", nGot, 0);

    // R3 R5 R6 R7 R2 table of blocks
    for (int v = 0; v < NVEC; v++) begin
      plainBlock(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 0);
      runStim(nsymFor(VEC[v][0]) * (VEC[v][1] + 1) + 4);
      compare("R6", 1);
      syndromeCheck(nsymFor(VEC[v][0]), VEC[v][1] + 1, VEC[v][2]);
    end

    // R3 gaps in validIn (with startIn high on idle cycles) are not counted
    plainBlock(2, 1, 6, 11, 3);
    runStim(12);
    compare("R3", 0);

    // R8 inputs during emission ignored
    plainBlock(3, 1, 7, 12, 0);
    for (int i = 0; i < 12; i++) begin
      stV[nSt + i] = 1; stS[nSt + i] = 1; stD[nSt + i] = 8'(i * 17 + 1);
    end
    nSt = nSt + 12;
    runStim(4);
    compare("R8", 1);

    // R9 configuration change after start has no effect
    plainBlock(4, 1, 5, 13, 0);
    chgAt = 2;
    runStim(20);
    chgAt = -1;
    compare("R9", 1);

    // R10 restart in mid-block
    plainBlock(1, 0, 8, 14, 0);
    for (int i = nSt - 1; i >= 0; i--) begin
      stV[i + 3] = stV[i]; stS[i + 3] = stS[i]; stD[i + 3] = stD[i];
    end
    for (int i = nExp - 1; i >= 0; i--) begin expD[i + 3] = expD[i]; expC[i + 3] = expC[i]; end
    for (int i = 0; i < 3; i++) begin
      stV[i] = 1; stS[i] = (i == 0); stD[i] = 8'(100 + i);
      expD[i] = 8'(100 + i); expC[i] = 0;
    end
    nSt += 3; nExp += 3;
    runStim(6);
    compare("R10", 1);

    // R2 next block after all of the above still encodes correctly
    plainBlock(0, 2, 4, 15, 0);
    runStim(10);
    compare("R2", 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule